// File: doc/BRIEF.md
# Reference-Locked Digital PLL Core

This block is an all-digital phase-locked loop clocked by a fast system clock. A phase accumulator acts as the digitally controlled oscillator: every system cycle it adds the current frequency word, and each wrap of the accumulator is one output tick. The nominal word gives a 65.536 MHz tick rate from the system clock. An upstream reference front end supplies a one-cycle pulse on each rising edge of the reference, a code for the reference rate it has detected, and a mode input that selects normal or freerun operation.

On each reference pulse the phase detector captures the top bits of the accumulator as a signed phase error. This is where the oscillator cycle sits relative to the reference edge. In normal mode a first-order filter then steers the frequency word against that error. The filter gain is an arithmetic right shift chosen by the rate code, and the 8 kHz rate gets a much narrower loop. The word is held within ±130 ppm of nominal. In freerun mode the reference is not used for steering, and the word falls back to nominal, so the output is exactly as accurate as the system clock.

Top module: `dpll_core`

## Requirements
- R1: While reset is asserted and just after it is released, `freq_word` equals NOM_FW (4398047 by default), `phase_err` is 0 and `dco_tick` is 0.
- R2: The ACC_W-bit accumulator adds `freq_word` on every clock edge. `dco_tick` is high for exactly the one cycle after an addition that carries out of bit ACC_W-1.
- R3: When `ref_edge` is high at a clock edge, `phase_err` takes bits [ACC_W-1 : ACC_W-ERR_W] of the accumulator value held before that edge, read as two's complement. Without `ref_edge`, `phase_err` holds its value.
- R4: In normal mode (`freerun`=0), on the clock edge after `phase_err` is updated, `freq_word` becomes `freq_word - (phase_err >>> shift)` (arithmetic shift). At all other times it holds.
- R5: The shift is SH_SLOW (6) for rate code 2'b00 (8 kHz). It is SH_FAST (2) for codes 2'b01, 2'b10 and 2'b11 (2.048, 8.192 and 16.384 MHz).
- R6: `freq_word` never leaves [NOM_FW-LIM, NOM_FW+LIM], where LIM = floor(NOM_FW*130/1e6) (571 by default). An update that would cross a limit lands on that limit.
- R7: While `freerun` is 1, `freq_word` is loaded with NOM_FW on every edge, and reference pulses do not change it. `phase_err` still follows R3.
- R8: After `freerun` returns to 0, steering under R4 resumes from NOM_FW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| ref_edge | input | 1 | One-cycle pulse per reference rising edge, already synchronized |
| rate_code | input | 2 | Detected reference rate: 00 8 kHz, 01 2.048 MHz, 10 8.192 MHz, 11 16.384 MHz |
| freerun | input | 1 | 1 = freerun (nominal word), 0 = normal (steered) |
| dco_tick | output | 1 | One-cycle pulse per oscillator cycle |
| phase_err | output | ERR_W | Signed phase error captured on the last reference pulse |
| freq_word | output | ACC_W | Current frequency word |

## Verification
A reference pulse sampled at edge k changes `phase_err` right after edge k. The matching `freq_word` step appears after edge k+1, and the accumulator uses the new word from edge k+2. `dco_tick` reflects the carry of the addition made on the edge just before. The bench keeps a cycle-by-cycle model that follows this register chain. It drives inputs on falling edges and compares all three outputs on every falling edge, so each result is checked exactly in the cycle it is due. Directed runs place reference pulses at fixed offsets after a tick, which forces the error sign so that both clamp limits are reached. They also switch freerun on and off around steered states.

// File: rtl/dpll_pkg.sv
package dpll_pkg;

  typedef enum logic [1:0] {
    RATE_8K  = 2'b00,
    RATE_2M  = 2'b01,
    RATE_8M  = 2'b10,
    RATE_16M = 2'b11
  } rate_e;

endpackage

// File: rtl/dpll_dco.sv
module dpll_dco #(
  parameter int ACC_W = 24,
  parameter int ERR_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] fw,
  output logic [ERR_W-1:0] phase_top,
  output logic             tick
);

  logic [ACC_W-1:0] acc_q, acc_nx;
  logic             carry;

  always_comb begin
    {carry, acc_nx} = {1'b0, acc_q} + {1'b0, fw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      tick  <= 1'b0;
    end else begin
      acc_q <= acc_nx;
      tick  <= carry;
    end
  end

  assign phase_top = acc_q[ACC_W-1 -: ERR_W];

  // a word below half scale can never wrap on two edges in a row
  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R2

endmodule

// File: rtl/dpll_phase_det.sv
module dpll_phase_det #(
  parameter int ERR_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_edge,
  input  logic [ERR_W-1:0]        phase_top,
  output logic signed [ERR_W-1:0] err,
  output logic                    err_vld
);

  logic signed [ERR_W-1:0] err_nx;

  always_comb begin
    err_nx = ref_edge ? $signed(phase_top) : err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err     <= '0;
      err_vld <= 1'b0;
    end else begin
      err     <= err_nx;
      err_vld <= ref_edge;
    end
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_edge |=> $stable(err)); // R3

endmodule

// File: rtl/dpll_loop_filter.sv
module dpll_loop_filter
  import dpll_pkg::*;
#(
  parameter int ACC_W   = 24,
  parameter int ERR_W   = 12,
  parameter int NOM_FW  = 4398047,
  parameter int LIM     = 571,
  parameter int SH_FAST = 2,
  parameter int SH_SLOW = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [ERR_W-1:0] err,
  input  logic                    err_vld,
  input  logic [1:0]              rate_code,
  input  logic                    freerun,
  output logic [ACC_W-1:0]        fw
);

  localparam int SW = ACC_W + 2;
  localparam logic signed [SW-1:0] FW_LO = SW'(NOM_FW - LIM);
  localparam logic signed [SW-1:0] FW_HI = SW'(NOM_FW + LIM);

  logic [4:0]              sh;
  logic signed [SW-1:0]    err_ext, step, cand;
  logic [ACC_W-1:0]        fw_nx;
  logic                    fw_en;

  always_comb begin
    case (rate_e'(rate_code))
      RATE_8K: sh = 5'(SH_SLOW);
      default: sh = 5'(SH_FAST);
    endcase
  end

  always_comb begin
    err_ext = SW'(err);
    step    = err_ext >>> sh;
    cand    = $signed({2'b00, fw}) - step;
    fw_en   = freerun | err_vld;
    if (freerun)
      fw_nx = ACC_W'(NOM_FW);
    else if (cand < FW_LO)
      fw_nx = FW_LO[ACC_W-1:0];
    else if (cand > FW_HI)
      fw_nx = FW_HI[ACC_W-1:0];
    else
      fw_nx = cand[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      fw <= ACC_W'(NOM_FW);
    else if (fw_en)
      fw <= fw_nx;
  end

  AST_FW_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($signed({2'b00, fw}) >= FW_LO) && ($signed({2'b00, fw}) <= FW_HI)); // R6
  AST_FREERUN_NOM: assert property (@(posedge clk) disable iff (!rst_n)
    freerun |=> (fw == ACC_W'(NOM_FW))); // R7
  AST_FW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!freerun && !err_vld) |=> $stable(fw)); // R4

endmodule

// File: rtl/dpll_core.sv
module dpll_core #(
  parameter int ACC_W   = 24,
  parameter int ERR_W   = 12,
  parameter int NOM_FW  = 4398047,
  parameter int PPM_LIM = 130,
  parameter int SH_FAST = 2,
  parameter int SH_SLOW = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_edge,
  input  logic [1:0]              rate_code,
  input  logic                    freerun,
  output logic                    dco_tick,
  output logic signed [ERR_W-1:0] phase_err,
  output logic [ACC_W-1:0]        freq_word
);

  localparam longint LIM_L = (longint'(NOM_FW) * longint'(PPM_LIM)) / 64'd1000000;
  localparam int     LIM   = int'(LIM_L);

  logic [ERR_W-1:0] phase_top;
  logic             err_vld;

  dpll_dco #(.ACC_W(ACC_W), .ERR_W(ERR_W)) u_dco (
    .clk       (clk),
    .rst_n     (rst_n),
    .fw        (freq_word),
    .phase_top (phase_top),
    .tick      (dco_tick)
  );

  dpll_phase_det #(.ERR_W(ERR_W)) u_pd (
    .clk       (clk),
    .rst_n     (rst_n),
    .ref_edge  (ref_edge),
    .phase_top (phase_top),
    .err       (phase_err),
    .err_vld   (err_vld)
  );

  dpll_loop_filter #(
    .ACC_W   (ACC_W),
    .ERR_W   (ERR_W),
    .NOM_FW  (NOM_FW),
    .LIM     (LIM),
    .SH_FAST (SH_FAST),
    .SH_SLOW (SH_SLOW)
  ) u_lf (
    .clk       (clk),
    .rst_n     (rst_n),
    .err       (phase_err),
    .err_vld   (err_vld),
    .rate_code (rate_code),
    .freerun   (freerun),
    .fw        (freq_word)
  );

endmodule

// File: tb/dpll_core_bench.sv
module dpll_core_bench;

  localparam int ACC_W = 24;
  localparam int ERR_W = 12;
  localparam longint NOM = 4398047;
  localparam longint LIM = (NOM * 130) / 1000000;

  logic clk = 1'b0;
  logic rst_n;
  logic ref_edge;
  logic [1:0] rate_code;
  logic freerun;
  logic dco_tick;
  logic signed [ERR_W-1:0] phase_err;
  logic [ACC_W-1:0] freq_word;

  int n_cmp = 0;
  int n_bad = 0;
  bit cmp_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  dpll_core u_dpll_core (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .rate_code(rate_code),
    .freerun(freerun), .dco_tick(dco_tick), .phase_err(phase_err),
    .freq_word(freq_word)
  );

  // bench model state
  logic [ACC_W-1:0] m_acc;
  logic             m_tick;
  logic signed [ERR_W-1:0] m_err;
  logic             m_vld;
  longint           m_fw;

  function automatic int f_shift(input logic [1:0] rc);
    return (rc == 2'b00) ? 6 : 2;
  endfunction

  function automatic longint f_clamp(input longint v);
    if (v < NOM - LIM) return NOM - LIM;
    if (v > NOM + LIM) return NOM + LIM;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = '0; m_tick = 1'b0; m_err = '0; m_vld = 1'b0; m_fw = NOM;
    end else begin
      logic [ACC_W:0] sum;
      longint fw_n;
      sum = {1'b0, m_acc} + {1'b0, ACC_W'(m_fw)};
      fw_n = m_fw;
      if (freerun) fw_n = NOM;
      else if (m_vld) fw_n = f_clamp(m_fw - (longint'(m_err) >>> f_shift(rate_code)));
      if (ref_edge) m_err = $signed(m_acc[ACC_W-1 -: ERR_W]);
      m_vld  = ref_edge;
      m_tick = sum[ACC_W];
      m_acc  = sum[ACC_W-1:0];
      m_fw   = fw_n;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      chk("R2 tick", longint'(dco_tick), longint'(m_tick));
      chk("R3 phase_err", longint'(phase_err), longint'(m_err));
      if (rate_code == 2'b00 && !freerun)
        chk("R5 freq_word slow gain", longint'(freq_word), m_fw);
      else
        chk("R4 freq_word", longint'(freq_word), m_fw);
    end
  end

  task automatic wait_tick();
    @(negedge clk);
    while (!dco_tick) @(negedge clk);
  endtask

  task automatic pulse_after_tick(input int gap);
    wait_tick();
    repeat (gap) @(negedge clk);
    ref_edge = 1'b1;
    @(negedge clk);
    ref_edge = 1'b0;
  endtask

  task automatic random_run(input int cycles, input bit slow);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      ref_edge  = (($urandom % 8) == 0);
      rate_code = slow ? 2'b00 : 2'(1 + ($urandom % 3));
    end
    @(negedge clk);
    ref_edge = 1'b0;
  endtask

  initial begin
    #400000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; ref_edge = 1'b0; rate_code = 2'b01; freerun = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset freq_word", longint'(freq_word), NOM);
    chk("R1 reset phase_err", longint'(phase_err), 0);
    chk("R1 reset tick", longint'(dco_tick), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release freq_word", longint'(freq_word), NOM);
    cmp_on = 1'b1;

    // freerun: reference pulses must not move the word (R7)
    random_run(300, 1'b0);
    chk("R7 freerun word", longint'(freq_word), NOM);

    // normal mode, fast rates, then the 8 kHz rate (R4, R5)
    freerun = 1'b0;
    random_run(3000, 1'b0);
    random_run(3000, 1'b1);

    // drive to the low clamp: edges where the error is positive (R6)
    rate_code = 2'b01;
    for (int k = 0; k < 24; k++) pulse_after_tick(1);
    repeat (3) @(negedge clk);
    chk("R6 low clamp", longint'(freq_word), NOM - LIM);

    // drive to the high clamp: edges where the error is negative (R6)
    for (int k = 0; k < 48; k++) pulse_after_tick(2);
    repeat (3) @(negedge clk);
    chk("R6 high clamp", longint'(freq_word), NOM + LIM);

    // freerun reloads nominal on the next edge (R7)
    freerun = 1'b1;
    @(negedge clk);
    chk("R7 freerun reload", longint'(freq_word), NOM);
    pulse_after_tick(1);
    repeat (2) @(negedge clk);
    chk("R7 edge ignored", longint'(freq_word), NOM);

    // leave freerun: first step starts from nominal (R8)
    freerun = 1'b0;
    pulse_after_tick(1);
    @(negedge clk);
    chk("R8 resume from nominal", longint'(freq_word),
        f_clamp(NOM - (longint'(phase_err) >>> 2)));
    random_run(1500, 1'b0);

    cmp_on = 1'b0;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule